// File: doc/BRIEF.md
# Fabric Configuration Sequencer

This block steers the configuration of an attached programmable-logic fabric from a small word-addressed register bus. Software sets control bits to pull the fabric's active-low configuration reset, enables the transfer of configuration words, and then programs a count of trailing configuration clocks. Software polls a status register, because no interrupt reports mode changes.

The status register carries a three-bit mode field. This field follows the fabric's progress through five phases: power-up, reset, configuration, initialisation and user mode. The phases advance on the fabric's done input and its active-low status input. Data words pass to the fabric only while transfer is allowed. Bytes that the write does not enable go out as zero. A rejected word raises a sticky error bit. A completion flag marks the end of the trailing clock burst. Both sticky bits are cleared by writing 1 to them.

Top module: `cfgmgr_ctrl`

Register word addresses: 0 control, 1 status, 2 data, 3 clock count.

## Requirements
- R1: While `rst` is high and after it falls, the following all hold until the first write: the mode reads 0 (power-up), the control register reads 0, both sticky bits read 0, the count reads 0, `fab_ncfg` is 1, `fab_dclk` is 0 and `fab_data_vld` is 0.
- R2: Status bits [2:0] hold the mode and can be read at any time. The encodings are power-up 0, reset 1, configuration 2, init 3, user 4, unknown 5. The mode never reads a value above 4.
- R3: Control bit 1 is the reset pull. Once it is written to 1, `fab_ncfg` is 0, and on the next clock the mode reads 1, whatever phase it was in.
- R4: Suppose bit 1 is cleared while the mode is reset, `fab_nstatus` is 1 and no failure is latched. Then the mode reads 2 one clock after the write.
- R5: A data-register write is forwarded when control bit 0 (enable) and bit 2 (transfer) are both 1 and no failure is latched. `fab_data_vld` is then high for exactly one cycle after the write, with the word on `fab_data`.
- R6: Each byte lane whose `bus_be` bit is 0 appears as zero on `fab_data`. Each lane whose bit is 1 carries the written byte.
- R7: A data write that is not forwarded leaves `fab_data_vld` at 0 and sets status bit 4. Bit 4 stays set until a status write with bit 4 at 1 clears it.
- R8: In configuration mode, with `fab_done` and `fab_nstatus` both 1, the mode reads 3 one clock later.
- R9: In configuration mode, a low `fab_nstatus` moves the mode to 1 on the next clock and latches a failure. While the failure is latched, the mode stays in reset and data writes are dropped. The failure is released only by setting the reset pull again.
- R10: Writing N to the count register (low CNT_W bits kept) drives `fab_dclk` high for exactly N cycles. At the end, status bit 3 is set. Bit 3 stays set until a status write with bit 3 at 1 clears it.
- R11: Writing the count register while a burst is running restarts the burst with the new value. Status bit 3 is set only once, when the count reaches zero.
- R12: In init mode, when a trailing clock burst ends, the mode reads 4.
- R13: Control bits are read back as written. Bit 3 drives `fab_nce`, bits [5:4] drive `fab_width` and bits [7:6] drive `fab_ratio`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_be | input | DATA_W/8 | Byte enables, used by data writes |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| fab_ncfg | output | 1 | Active-low configuration reset to the fabric |
| fab_nce | output | 1 | Active-low chip enable to the fabric |
| fab_width | output | 2 | Configuration data width select |
| fab_ratio | output | 2 | Clock-to-data ratio select |
| fab_data | output | DATA_W | Configuration word to the fabric |
| fab_data_vld | output | 1 | Configuration word valid, one cycle per word |
| fab_dclk | output | 1 | Trailing configuration clock enable, high once per cycle of a burst |
| fab_done | input | 1 | Done indication from the fabric |
| fab_nstatus | input | 1 | Active-low status indication from the fabric |

## Verification
The bench builds the block with DATA_W = 32 and CNT_W = 6. The narrow counter lets it run bursts up to the all-ones count of 63 within a short run. It also exposes how the upper bits of a count write are truncated. Random bursts, random byte enables and random transfer gating are mixed with a directed walk through every mode transition. The walk includes a failure latched by a low status input and its release through a new reset pull.

// File: rtl/cfgmgr_ctrl.sv
module cfgmgr_ctrl #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_wr,
  input  logic [1:0]          bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W/8-1:0] bus_be,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                fab_ncfg,
  output logic                fab_nce,
  output logic [1:0]          fab_width,
  output logic [1:0]          fab_ratio,
  output logic [DATA_W-1:0]   fab_data,
  output logic                fab_data_vld,
  output logic                fab_dclk,
  input  logic                fab_done,
  input  logic                fab_nstatus
);
  localparam int BYTES = DATA_W / 8;
  localparam logic [1:0] A_CTL = 2'd0, A_STA = 2'd1, A_DAT = 2'd2, A_CNT = 2'd3;

  typedef enum logic [2:0] {
    M_PWR = 3'd0, M_RST = 3'd1, M_CFG = 3'd2, M_INIT = 3'd3, M_USER = 3'd4, M_UNK = 3'd5
  } mode_t;

  mode_t             mode;
  logic [7:0]        ctl;
  logic [CNT_W-1:0]  cnt;
  logic              done_f, err_f, lock;
  logic [DATA_W-1:0] masked;

  wire pull    = ctl[1];
  wire wr_ctl  = bus_wr && bus_addr == A_CTL;
  wire wr_sta  = bus_wr && bus_addr == A_STA;
  wire wr_dat  = bus_wr && bus_addr == A_DAT;
  wire wr_cnt  = bus_wr && bus_addr == A_CNT;
  wire accept  = ctl[0] && ctl[2] && !lock;
  wire cnt_end = (cnt == CNT_W'(1)) && !wr_cnt;

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign masked[b*8 +: 8] = bus_be[b] ? bus_wdata[b*8 +: 8] : 8'h00;
  end

  assign fab_ncfg  = ~pull;
  assign fab_nce   = ctl[3];
  assign fab_width = ctl[5:4];
  assign fab_ratio = ctl[7:6];
  assign fab_dclk  = |cnt;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTL: bus_rdata[7:0] = ctl;
      A_STA: bus_rdata[6:0] = {fab_nstatus, fab_done, err_f, done_f, mode};
      A_CNT: bus_rdata[CNT_W-1:0] = cnt;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode         <= M_PWR;
      ctl          <= '0;
      cnt          <= '0;
      done_f       <= 1'b0;
      err_f        <= 1'b0;
      lock         <= 1'b0;
      fab_data     <= '0;
      fab_data_vld <= 1'b0;
    end else begin
      fab_data_vld <= 1'b0;
      if (wr_ctl) ctl <= bus_wdata[7:0];
      if (wr_sta && bus_wdata[3]) done_f <= 1'b0;
      if (wr_sta && bus_wdata[4]) err_f  <= 1'b0;
      if (wr_dat) begin
        if (accept) begin
          fab_data_vld <= 1'b1;
          fab_data     <= masked;
        end else begin
          err_f <= 1'b1;
        end
      end
      if (wr_cnt)          cnt <= bus_wdata[CNT_W-1:0];
      else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
      if (cnt_end) done_f <= 1'b1;

      if (pull) lock <= 1'b0;
      else if (mode == M_CFG && !fab_nstatus) lock <= 1'b1;

      if (pull) mode <= M_RST;
      else begin
        case (mode)
          M_RST:  if (!lock && fab_nstatus) mode <= M_CFG;
          M_CFG:  if (!fab_nstatus) mode <= M_RST;
                  else if (fab_done) mode <= M_INIT;
          M_INIT: if (cnt_end) mode <= M_USER;
          M_UNK:  mode <= M_RST;
          default: mode <= mode;
        endcase
      end
    end
  end

  // R2
  mode_range_chk: assert property (@(posedge clk) disable iff (rst) mode <= M_USER);
  // R3
  pull_mode_chk: assert property (@(posedge clk) disable iff (rst) pull |=> mode == M_RST);
  // R7
  drop_err_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_dat && !accept) |=> (!fab_data_vld && err_f));
  // R9
  fail_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == M_CFG && !fab_nstatus && !pull) |=> mode == M_RST);
  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done_f && !(wr_sta && bus_wdata[3])) |=> done_f);
  // R11
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0 && !wr_cnt) |=> cnt == $past(cnt) - CNT_W'(1));
endmodule

// File: tb/cfgmgr_ctrl_test.sv
`timescale 1ns/1ps
module cfgmgr_ctrl_test;
  localparam int DW = 32;
  localparam int CW = 6;

  logic clk = 0, rst = 1;
  logic bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [DW-1:0] bus_wdata = 0;
  logic [3:0] bus_be = 0;
  logic [DW-1:0] bus_rdata;
  logic fab_ncfg, fab_nce, fab_data_vld, fab_dclk;
  logic [1:0] fab_width, fab_ratio;
  logic [DW-1:0] fab_data;
  logic fab_done = 0, fab_nstatus = 0;
  int total = 0, failed = 0;

  cfgmgr_ctrl #(.DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_rdata(bus_rdata), .fab_ncfg(fab_ncfg), .fab_nce(fab_nce),
    .fab_width(fab_width), .fab_ratio(fab_ratio), .fab_data(fab_data),
    .fab_data_vld(fab_data_vld), .fab_dclk(fab_dclk), .fab_done(fab_done),
    .fab_nstatus(fab_nstatus));

  always #2.5 clk = ~clk;

  function automatic logic [31:0] lane_mask(input logic [31:0] d, input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[b*8 +: 8] = be[b] ? d[b*8 +: 8] : 8'h00;
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
    bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic mode_is(input string req, input logic [2:0] m);
    logic [31:0] v;
    rd(2'd1, v);
    chk(req, {29'd0, v[2:0]}, {29'd0, m});
  endtask

  task automatic burst(input string req, input int n, input logic [2:0] m_after);
    logic [31:0] v;
    int pulses = 0;
    int guard = 0;
    wr(2'd3, n, 4'hF);
    rd(2'd1, v);
    while (!v[3] && guard < 200) begin
      if (fab_dclk) pulses++;
      tick(); guard++;
      rd(2'd1, v);
    end
    chk(req, pulses, n);
    chk(req, {29'd0, v[2:0]}, {29'd0, m_after});
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    total++; failed++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v, d;
    logic [3:0] be;
    void'($urandom(32'd2024));
    @(negedge clk);
    tick(); tick(); tick();
    // R1
    chk("R1 ncfg in reset", fab_ncfg, 1);
    rst = 0;
    tick();
    rd(2'd1, v); chk("R1 status", v, 32'h0);
    rd(2'd0, v); chk("R1 control", v, 32'h0);
    rd(2'd3, v); chk("R1 count", v, 32'h0);
    chk("R1 ncfg", fab_ncfg, 1);
    chk("R1 dclk", fab_dclk, 0);
    chk("R1 vld", fab_data_vld, 0);

    // R13
    wr(2'd0, 32'h61, 4'hF);
    rd(2'd0, v); chk("R13 readback", v, 32'h61);
    chk("R13 width", fab_width, 2); chk("R13 ratio", fab_ratio, 1); chk("R13 nce", fab_nce, 0);
    wr(2'd0, 32'h69, 4'hF);
    chk("R13 nce high", fab_nce, 1);

    // R3
    wr(2'd0, 32'h63, 4'hF);
    chk("R3 ncfg low", fab_ncfg, 0);
    tick();
    mode_is("R3 mode reset", 3'd1);

    // R4
    fab_nstatus = 1;
    wr(2'd0, 32'h61, 4'hF);
    mode_is("R4 still reset", 3'd1);
    tick();
    mode_is("R4 config", 3'd2);
    rd(2'd1, v); chk("R2 status pins", v[6:5], 2'b10);

    // R7
    wr(2'd2, 32'hDEADBEEF, 4'hF);
    chk("R7 dropped vld", fab_data_vld, 0);
    rd(2'd1, v); chk("R7 err set", v[4], 1);
    tick(); rd(2'd1, v); chk("R7 err sticky", v[4], 1);
    wr(2'd1, 32'h10, 4'hF);
    rd(2'd1, v); chk("R7 err cleared", v[4], 0);

    // R5 / R6 random words
    wr(2'd0, 32'h65, 4'hF);
    for (int i = 0; i < 40; i++) begin
      d = $urandom;
      case ($urandom % 4)
        0: be = 4'h1; 1: be = 4'h3; 2: be = 4'h7; default: be = 4'hF;
      endcase
      if ($urandom % 5 == 0) begin
        wr(2'd0, 32'h61, 4'hF);
        wr(2'd2, d, be);
        chk("R7 random drop", fab_data_vld, 0);
        rd(2'd1, v); chk("R7 random err", v[4], 1);
        wr(2'd1, 32'h10, 4'hF);
        wr(2'd0, 32'h65, 4'hF);
      end else begin
        wr(2'd2, d, be);
        chk("R5 vld", fab_data_vld, 1);
        chk("R6 lanes", fab_data, lane_mask(d, be));
        tick();
        chk("R5 one cycle", fab_data_vld, 0);
      end
    end
    mode_is("R2 mode during data", 3'd2);

    // R8
    fab_done = 1;
    tick();
    mode_is("R8 init", 3'd3);

    // R10 / R12
    wr(2'd0, 32'h61, 4'hF);
    burst("R10 four clocks", 4, 3'd4);
    mode_is("R12 user", 3'd4);
    repeat (5) tick();
    rd(2'd1, v); chk("R10 done sticky", v[3], 1);
    wr(2'd1, 32'h08, 4'hF);
    rd(2'd1, v); chk("R10 done cleared", v[3], 0);
    wr(2'd0, 32'h00, 4'hF);
    rd(2'd0, v); chk("R13 enable cleared", v, 0);

    for (int i = 0; i < 6; i++) begin
      burst("R10 random burst", 1 + ($urandom % 62), 3'd4);
      wr(2'd1, 32'h08, 4'hF);
    end
    burst("R10 max burst", 63, 3'd4);
    wr(2'd1, 32'h08, 4'hF);

    // R10 count truncation to CNT_W bits
    wr(2'd3, 32'h47, 4'hF);
    rd(2'd3, v); chk("R10 truncated count", v, 7);
    repeat (10) tick();
    wr(2'd1, 32'h08, 4'hF);

    // R11
    wr(2'd3, 10, 4'hF);
    tick(); tick(); tick();
    rd(2'd1, v); chk("R11 no early done", v[3], 0);
    burst("R11 restart", 5, 3'd4);
    wr(2'd1, 32'h08, 4'hF);
    repeat (20) tick();
    rd(2'd1, v); chk("R11 done once", v[3], 0);

    // R9
    fab_done = 0; fab_nstatus = 0;
    wr(2'd0, 32'h63, 4'hF);
    tick();
    mode_is("R3 reset from user", 3'd1);
    fab_nstatus = 1;
    wr(2'd0, 32'h65, 4'hF);
    tick();
    mode_is("R4 config again", 3'd2);
    fab_nstatus = 0;
    tick();
    mode_is("R9 back to reset", 3'd1);
    fab_nstatus = 1;
    repeat (4) tick();
    mode_is("R9 held in reset", 3'd1);
    wr(2'd2, 32'h12345678, 4'hF);
    chk("R9 data dropped", fab_data_vld, 0);
    rd(2'd1, v); chk("R9 err set", v[4], 1);
    wr(2'd1, 32'h10, 4'hF);
    wr(2'd0, 32'h67, 4'hF);
    wr(2'd0, 32'h65, 4'hF);
    tick();
    mode_is("R9 recovered", 3'd2);
    wr(2'd2, 32'hCAFEF00D, 4'h3);
    chk("R9 data accepted", fab_data_vld, 1);
    chk("R6 after recovery", fab_data, 32'h0000F00D);

    finish_run();
  end
endmodule